// File: doc/BRIEF.md
# Command Effects Log Builder

This block builds, by itself, a log of the commands a device supports and what side effects each one has. After reset it walks a table of commands through a read port, one command-set/command pair per clock. For every pair that the table marks as implemented, it stores a four-byte record in an internal log memory. Once the walk is complete it accepts queries on a request/response handshake.

A query is one of two kinds. The directory query returns a fixed 28-byte summary: the number of logs (always one), reserved zeros, the log's 128-bit identifier and the log size in bytes. The read query names an identifier, a byte offset and a byte length. It returns that slice of the log as a byte stream. A read is refused when the requested range does not fit the payload area, or when the identifier is not the log's own. Each refusal has its own return code. Every query ends with a single completion beat that carries the return code and the number of bytes produced.

Top module: `cel_builder`

## Requirements
- R1: After reset, `qReady` stays low while the command table is walked. `tblAddr` starts at 0 and rises by one per clock, with the command set in the upper byte and the command in the lower byte. `qReady` first reads high after exactly 2^(SET_W+CMD_W) rising edges following reset release.
- R2: Each table address that reports `tblHit` adds one record to the log, in walk order. Record i takes log bytes 4i..4i+3: opcode low byte, opcode high byte, effect low byte, effect high byte.
- R3: The effect mask is stored exactly as the table gives it. In that mask, bit 1 flags an immediate configuration change, bit 2 an immediate data change, bit 3 an immediate policy change and bit 4 an immediate log change.
- R4: A directory query (`qKind`=0) returns code 0 and length 28, with these bytes: byte 0 = 1; bytes 1..7 = 0; bytes 8..23 = identifier bytes, least significant first; bytes 24..27 = 4 × record count, little-endian. The identifier, offset and length inputs are ignored.
- R5: A read query (`qKind`=1) whose offset + length, summed without overflow, exceeds PAYLOAD_BYTES returns code 2 and length 0, and streams no bytes. An offset of 0xFFFFFFFF with a nonzero length is therefore refused.
- R6: A read query that is within range but has an identifier other than LOG_ID returns code 3 and length 0, and streams no bytes. When the range check and the identifier check both fail, the code is 2.
- R7: An accepted read returns code 0 and length equal to the requested length. It streams the log bytes from the offset onward, and any byte at or beyond 4 × record count reads as 0. A zero length streams nothing.
- R8: A streamed byte and `rspLast` are held while `rspReady` is low. `rspLast` marks the final byte. `doneValid` is high for exactly one clock after the stream ends, or directly after acceptance when there is nothing to stream. `qReady` is low from acceptance until after `doneValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tblAddr | output | SET_W+CMD_W | Command table address, {set, command} |
| tblHit | input | 1 | The addressed command is implemented (combinational reply) |
| tblEffect | input | 16 | Effect mask of the addressed command |
| qValid | input | 1 | Query request valid |
| qReady | output | 1 | Block can accept a query |
| qKind | input | 1 | 0 directory query, 1 read query |
| qId | input | 128 | Identifier for a read query |
| qOffset | input | 32 | Byte offset for a read query |
| qLength | input | 32 | Byte length for a read query |
| rspValid | output | 1 | Response byte valid |
| rspReady | input | 1 | Consumer takes the response byte |
| rspData | output | 8 | Response byte |
| rspLast | output | 1 | Final response byte |
| doneValid | output | 1 | Completion beat |
| doneCode | output | 5 | Return code (0 ok, 2 out of range, 3 unknown identifier) |
| doneLen | output | 32 | Bytes produced by the query |

## Verification
The hardest cases to reach from the ports are the edges of the range check. These are a sum that wraps in 32 bits, a range that ends exactly at the payload limit, and a range that reaches past the last stored record but stays inside the payload. The stimulus reaches each one with directed offset/length pairs: 0xFFFFFFFF+2, 200+56, 256+0, 250+7 and 50+8. The expected bytes come from a log image that the bench rebuilds from its own copy of the command table. The consumer stalls on a repeating pattern, so every byte is also seen held across a stall.

// File: rtl/cel_pkg.sv
package cel_pkg;
  localparam int CodeW    = 5;
  localparam int SupBytes = 28;

  localparam logic [CodeW-1:0] RC_OK        = 5'h00;
  localparam logic [CodeW-1:0] RC_BAD_INPUT = 5'h02;
  localparam logic [CodeW-1:0] RC_UNSUPP    = 5'h03;

  typedef enum logic [1:0] {
    ST_SCAN,
    ST_IDLE,
    ST_STREAM,
    ST_DONE
  } cel_state_e;

  typedef struct packed {
    logic scanStep;
    logic load;
    logic advance;
  } cel_strobe_t;
endpackage

// File: rtl/cel_dpath.sv
module cel_dpath
  import cel_pkg::*;
#(
  parameter int SET_W = 8,
  parameter int CMD_W = 8,
  parameter int MAX_ENTRIES = 64,
  parameter int PAYLOAD_BYTES = 256,
  parameter logic [127:0] LOG_ID = 128'h5a1c93e07b244d6fa8c10e3f62d9b457
) (
  input  logic                   clk,
  input  logic                   rst,
  input  cel_strobe_t            strobe,
  output logic [SET_W+CMD_W-1:0] tblAddr,
  input  logic                   tblHit,
  input  logic [15:0]            tblEffect,
  input  logic                   qKind,
  input  logic [127:0]           qId,
  input  logic [31:0]            qOffset,
  input  logic [31:0]            qLength,
  output logic                   scanAtEnd,
  output logic                   qHasBytes,
  output logic [7:0]             rspData,
  output logic                   rspLast,
  output logic [CodeW-1:0]       codeReg,
  output logic [31:0]            lenReg
);
  localparam int OpW  = SET_W + CMD_W;
  localparam int CntW = $clog2(MAX_ENTRIES + 1);
  localparam int IdxW = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1;

  logic [OpW-1:0]   scanIdx;
  logic [CntW-1:0]  entryCount;
  logic [31:0]      logMem [MAX_ENTRIES];
  logic             kindReg;
  logic [31:0]      byteIdx;
  logic [31:0]      remaining;

  // Query decode: range check first, identifier second.
  logic [32:0]      rangeEnd;
  logic             overRange;
  logic             idMiss;
  logic [CodeW-1:0] newCode;
  logic [31:0]      newLen;
  logic [31:0]      newStart;

  always_comb begin
    rangeEnd  = {1'b0, qOffset} + {1'b0, qLength};
    overRange = rangeEnd > 33'(PAYLOAD_BYTES);
    idMiss    = qId != LOG_ID;
    newStart  = qKind ? qOffset : 32'd0;
    if (!qKind) begin
      newCode = RC_OK;
      newLen  = 32'(SupBytes);
    end else if (overRange) begin
      newCode = RC_BAD_INPUT;
      newLen  = 32'd0;
    end else if (idMiss) begin
      newCode = RC_UNSUPP;
      newLen  = 32'd0;
    end else begin
      newCode = RC_OK;
      newLen  = qLength;
    end
    qHasBytes = newLen != 32'd0;
  end

  // Table walk and record counter.
  assign tblAddr   = scanIdx;
  assign scanAtEnd = &scanIdx;

  logic appendNow;
  assign appendNow = strobe.scanStep && tblHit && (entryCount < CntW'(MAX_ENTRIES));

  always_ff @(posedge clk) begin
    if (rst) begin
      scanIdx    <= '0;
      entryCount <= '0;
    end else if (strobe.scanStep) begin
      scanIdx <= scanIdx + 1'b1;
      if (appendNow) entryCount <= entryCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (appendNow) logMem[entryCount[IdxW-1:0]] <= {tblEffect, 16'(scanIdx)};
  end

  // Query registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      kindReg   <= 1'b0;
      byteIdx   <= '0;
      remaining <= '0;
      codeReg   <= RC_OK;
      lenReg    <= '0;
    end else if (strobe.load) begin
      kindReg   <= qKind;
      byteIdx   <= newStart;
      remaining <= newLen;
      codeReg   <= newCode;
      lenReg    <= newLen;
    end else if (strobe.advance) begin
      byteIdx   <= byteIdx + 32'd1;
      remaining <= remaining - 32'd1;
    end
  end

  assign rspLast = remaining == 32'd1;

  // Byte generation.
  logic [31:0] logLimit;
  logic [31:0] entryWord;
  logic [7:0]  logByte;
  logic [7:0]  supByte;
  logic [31:0] sizeWord;
  logic [4:0]  supIdx;
  logic [4:0]  idIdx;

  always_comb begin
    logLimit  = 32'(entryCount) << 2;
    sizeWord  = logLimit;
    entryWord = (byteIdx < logLimit) ? logMem[byteIdx[IdxW+1:2]] : 32'd0;
    logByte   = entryWord[{byteIdx[1:0], 3'b000} +: 8];

    supIdx = byteIdx[4:0];
    idIdx  = supIdx - 5'd8;
    if (supIdx == 5'd0)                       supByte = 8'h01;
    else if (supIdx >= 5'd8 && supIdx < 5'd24)  supByte = LOG_ID[{idIdx[3:0], 3'b000} +: 8];
    else if (supIdx >= 5'd24 && supIdx < 5'd28) supByte = sizeWord[{supIdx[1:0], 3'b000} +: 8];
    else                                        supByte = 8'h00;

    rspData = kindReg ? logByte : supByte;
  end

  // R2: the log grows by at most one record per clock.
  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    (entryCount - $past(entryCount)) <= CntW'(1));

  // R5: a successful read never reports more bytes than the payload area.
  a_r5_len_in_payload: assert property (@(posedge clk) disable iff (rst)
    (kindReg && codeReg == RC_OK) |-> lenReg <= 32'(PAYLOAD_BYTES));
endmodule

// File: rtl/cel_ctrl.sv
module cel_ctrl
  import cel_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             qValid,
  output logic             qReady,
  input  logic             rspReady,
  output logic             rspValid,
  output logic             doneValid,
  input  logic             scanAtEnd,
  input  logic             qHasBytes,
  input  logic             rspLast,
  input  logic [CodeW-1:0] codeReg,
  output cel_strobe_t      strobe
);
  cel_state_e state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_SCAN;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    qReady    = 1'b0;
    rspValid  = 1'b0;
    doneValid = 1'b0;
    unique case (state)
      ST_SCAN: begin
        strobe.scanStep = 1'b1;
        if (scanAtEnd) nextState = ST_IDLE;
      end
      ST_IDLE: begin
        qReady = 1'b1;
        if (qValid) begin
          strobe.load = 1'b1;
          nextState   = qHasBytes ? ST_STREAM : ST_DONE;
        end
      end
      ST_STREAM: begin
        rspValid = 1'b1;
        if (rspReady) begin
          strobe.advance = 1'b1;
          if (rspLast) nextState = ST_DONE;
        end
      end
      ST_DONE: begin
        doneValid = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // R8: a stalled byte stays presented and keeps its last flag.
  a_r8_hold_stall: assert property (@(posedge clk) disable iff (rst)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspLast)));

  // R8: completion is a one-clock beat that reopens the request side.
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    doneValid |=> (!doneValid && qReady));

  // R8: an accepted query blocks further requests.
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (qValid && qReady) |=> !qReady);

  // R5, R6: refused queries produce no bytes.
  a_r6_stream_only_ok: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> codeReg == RC_OK);
endmodule

// File: rtl/cel_builder.sv
module cel_builder
  import cel_pkg::*;
#(
  parameter int SET_W = 8,
  parameter int CMD_W = 8,
  parameter int MAX_ENTRIES = 64,
  parameter int PAYLOAD_BYTES = 256,
  parameter logic [127:0] LOG_ID = 128'h5a1c93e07b244d6fa8c10e3f62d9b457
) (
  input  logic                   clk,
  input  logic                   rst,
  output logic [SET_W+CMD_W-1:0] tblAddr,
  input  logic                   tblHit,
  input  logic [15:0]            tblEffect,
  input  logic                   qValid,
  output logic                   qReady,
  input  logic                   qKind,
  input  logic [127:0]           qId,
  input  logic [31:0]            qOffset,
  input  logic [31:0]            qLength,
  output logic                   rspValid,
  input  logic                   rspReady,
  output logic [7:0]             rspData,
  output logic                   rspLast,
  output logic                   doneValid,
  output logic [4:0]             doneCode,
  output logic [31:0]            doneLen
);
  cel_strobe_t      strobe;
  logic             scanAtEnd;
  logic             qHasBytes;
  logic             dpLast;
  logic [CodeW-1:0] codeReg;

  cel_dpath #(
    .SET_W(SET_W), .CMD_W(CMD_W), .MAX_ENTRIES(MAX_ENTRIES),
    .PAYLOAD_BYTES(PAYLOAD_BYTES), .LOG_ID(LOG_ID)
  ) i_dpath (
    .clk(clk), .rst(rst), .strobe(strobe),
    .tblAddr(tblAddr), .tblHit(tblHit), .tblEffect(tblEffect),
    .qKind(qKind), .qId(qId), .qOffset(qOffset), .qLength(qLength),
    .scanAtEnd(scanAtEnd), .qHasBytes(qHasBytes),
    .rspData(rspData), .rspLast(dpLast),
    .codeReg(codeReg), .lenReg(doneLen)
  );

  cel_ctrl i_ctrl (
    .clk(clk), .rst(rst), .qValid(qValid), .qReady(qReady),
    .rspReady(rspReady), .rspValid(rspValid), .doneValid(doneValid),
    .scanAtEnd(scanAtEnd), .qHasBytes(qHasBytes), .rspLast(dpLast),
    .codeReg(codeReg), .strobe(strobe)
  );

  assign rspLast  = rspValid && dpLast;
  assign doneCode = codeReg;

  // R8: the byte under a stall does not change.
  a_r8_data_stable: assert property (@(posedge clk) disable iff (rst)
    (rspValid && !rspReady) |=> $stable(rspData));
endmodule

// File: tb/test_cel_builder.sv
module test_cel_builder;
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [127:0] ID = 128'h5a1c93e07b244d6fa8c10e3f62d9b457;
  localparam int PAY = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] tblAddr;
  logic tblHit;
  logic [15:0] tblEffect;
  logic qValid = 1'b0, qReady, qKind = 1'b0;
  logic [127:0] qId = '0;
  logic [31:0] qOffset = '0, qLength = '0;
  logic rspValid, rspReady, rspLast, doneValid;
  logic [7:0] rspData;
  logic [4:0] doneCode;
  logic [31:0] doneLen;

  int checks = 0, fails = 0;
  string curReq = "R1";
  bit stallMode = 1'b0;

  always #2.5 clk = ~clk;

  cel_builder i_cel_builder (
    .clk(clk), .rst(rst), .tblAddr(tblAddr), .tblHit(tblHit), .tblEffect(tblEffect),
    .qValid(qValid), .qReady(qReady), .qKind(qKind), .qId(qId),
    .qOffset(qOffset), .qLength(qLength), .rspValid(rspValid), .rspReady(rspReady),
    .rspData(rspData), .rspLast(rspLast), .doneValid(doneValid),
    .doneCode(doneCode), .doneLen(doneLen)
  );

  // Bench copy of the command table: {hit, effect}.
  function automatic logic [16:0] tblEntry(logic [15:0] a);
    case (a)
      16'h0100: return {1'b1, 16'h0000};
      16'h0101: return {1'b1, 16'h0010};
      16'h0102: return {1'b1, 16'h0000};
      16'h0103: return {1'b1, 16'h0002};
      16'h0200: return {1'b1, 16'h0000};
      16'h0300: return {1'b1, 16'h0000};
      16'h0301: return {1'b1, 16'h0008};
      16'h0400: return {1'b1, 16'h0000};
      16'h0401: return {1'b1, 16'h0000};
      16'h4000: return {1'b1, 16'h0000};
      16'h4100: return {1'b1, 16'h0000};
      16'h4102: return {1'b1, 16'h0000};
      16'h4103: return {1'b1, 16'h0006};
      default:  return 17'd0;
    endcase
  endfunction

  always_comb {tblHit, tblEffect} = tblEntry(tblAddr);

  logic [7:0] logImg [PAY];
  int logCount = 0;

  initial begin
    for (int i = 0; i < PAY; i++) logImg[i] = 8'h00;
    for (int a = 0; a < 65536; a++) begin
      logic [16:0] e;
      e = tblEntry(16'(a));
      if (e[16]) begin
        logImg[4*logCount]   = 8'(a);
        logImg[4*logCount+1] = 8'(a >> 8);
        logImg[4*logCount+2] = e[7:0];
        logImg[4*logCount+3] = e[15:8];
        logCount++;
      end
    end
  end

  logic [7:0]  expQ [$];
  logic [36:0] expDone [$];

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // Consumer stall pattern.
  initial begin
    int n = 0;
    rspReady = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      n++;
      rspReady = stallMode ? (n % 3 != 0) : 1'b1;
    end
  end

  // Monitor: pops expected items as the design produces them.
  logic       holdSeen = 1'b0;
  logic [7:0] holdData;
  always @(negedge clk) begin
    if (!rst) begin
      if (holdSeen) begin
        check(rspValid && rspData == holdData, "R8", "byte held under stall",
              longint'(rspData), longint'(holdData));
      end
      holdSeen = rspValid && !rspReady;
      holdData = rspData;
      if (rspValid && rspReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, curReq, "unexpected byte", longint'(rspData), 0);
        end else begin
          check(rspLast == (expQ.size() == 1), "R8", "last flag",
                longint'(rspLast), longint'(expQ.size() == 1));
          check(rspData == expQ[0], curReq, "byte", longint'(rspData), longint'(expQ[0]));
          void'(expQ.pop_front());
        end
      end
      if (doneValid) begin
        if (expDone.size() == 0) begin
          check(1'b0, curReq, "unexpected completion", longint'(doneCode), 0);
        end else begin
          check({doneCode, doneLen} == expDone[0], curReq, "code/len",
                longint'({doneCode, doneLen}), longint'(expDone[0]));
          check(expQ.size() == 0, "R8", "bytes left at completion", expQ.size(), 0);
          void'(expDone.pop_front());
        end
      end
    end
  end

  // Driver: computes expected items, then issues the query.
  task automatic sendQuery(string req, logic kind, logic [127:0] id, logic [31:0] off,
                           logic [31:0] len);
    curReq = req;
    if (!kind) begin
      logic [31:0] sz;
      sz = 32'(logCount * 4);
      for (int i = 0; i < 28; i++) begin
        if (i == 0)                 expQ.push_back(8'h01);
        else if (i >= 8 && i < 24)  expQ.push_back(id_byte(i - 8));
        else if (i >= 24)           expQ.push_back(sz[8*(i-24) +: 8]);
        else                        expQ.push_back(8'h00);
      end
      expDone.push_back({5'd0, 32'd28});
    end else if ({1'b0, off} + {1'b0, len} > 33'(PAY)) begin
      expDone.push_back({5'd2, 32'd0});
    end else if (id != ID) begin
      expDone.push_back({5'd3, 32'd0});
    end else begin
      for (int i = 0; i < int'(len); i++) expQ.push_back(logImg[int'(off) + i]);
      expDone.push_back({5'd0, len});
    end
    @(negedge clk);
    qKind = kind; qId = id; qOffset = off; qLength = len; qValid = 1'b1;
    while (!qReady) @(negedge clk);
    @(posedge clk);
    #1;
    qValid = 1'b0;
    qId = ~ID; qOffset = 32'hdead_beef; qLength = 32'hffff;
    while (expDone.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] id_byte(int k);
    return ID[8*k +: 8];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    int cyc = 0;
    int addrErr = 0;
    repeat (4) @(negedge clk);
    check(!qReady && !rspValid && !doneValid, "R8", "outputs idle in reset",
          longint'({qReady, rspValid, doneValid}), 0);
    rst = 1'b0;
    while (!qReady && cyc < 70000) begin
      if (tblAddr != 16'(cyc)) addrErr++;
      @(negedge clk);
      cyc++;
    end
    check(cyc == 65536, "R1", "cycles until ready", cyc, 65536);
    check(addrErr == 0, "R1", "table address order errors", addrErr, 0);

    // R4: directory query, inputs other than the kind ignored.
    sendQuery("R4", 1'b0, ~ID, 32'h1234, 32'h9999);
    stallMode = 1'b1;
    // R2, R3: whole log, including effect masks 0x10, 0x02, 0x08, 0x06.
    sendQuery("R2", 1'b1, ID, 32'd0, 32'(logCount * 4));
    sendQuery("R7", 1'b1, ID, 32'd6, 32'd10);
    sendQuery("R3", 1'b1, ID, 32'd48, 32'd4);
    // R7: past the last record, inside the payload: zeros.
    sendQuery("R7", 1'b1, ID, 32'd50, 32'd8);
    sendQuery("R7", 1'b1, ID, 32'd200, 32'd56);
    sendQuery("R7", 1'b1, ID, 32'd256, 32'd0);
    stallMode = 1'b0;
    sendQuery("R5", 1'b1, ID, 32'd250, 32'd7);
    sendQuery("R5", 1'b1, ID, 32'hffff_ffff, 32'd2);
    sendQuery("R6", 1'b1, ID ^ 128'h1, 32'd0, 32'd4);
    sendQuery("R6", 1'b1, ID ^ 128'h1, 32'd255, 32'd9);
    sendQuery("R4", 1'b0, ID, 32'd0, 32'd0);
    finishRun();
  end
endmodule